// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This controller keeps track of the power state of a small chip and drives its power-domain enables. An asynchronous external enable input has priority over everything else. While the enable is low, the chip is held in a disabled state with every enable off. When the enable goes high, a full power-on reset sequence runs.

Once the chip is running, it sits in an ON mode with two submodes:

- **Low-power:** the regulator and clock enables follow a vector of function-block request lines.
- **Constant-latency:** the regulator and clock enables are held on.

Two task pulses select the submode. A register write moves the chip into a deep OFF mode. If a debugger is attached at that moment, OFF is only emulated: the CPU and its support domains stay powered. Three wakeup events end OFF: a pin-detect pulse, a reset request and a debug-session start. Each of them ends OFF with a fixed-length system reset.

Every RAM block has its own power bit and retention bit. These bits sit in registers that survive OFF and wakeup resets. Only a fresh power-up reloads them.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_ni` is released, `mode_o` is 0 (DISABLED). In DISABLED, `reg_en_o`, `clk_en_o`, `cpu_run_o`, `sys_rst_o`, `dom_en_o`, `ram_pwr_o` and `ram_ret_o` are all 0.
- R2: `ext_en_i` passes through a two-flop synchroniser. A low level forces DISABLED on the third rising edge after the change, whatever the current mode. While DISABLED, wakeup, task, RAM-write and OFF-write inputs are ignored.
- R3: A rising `ext_en_i` starts RESET (code 6) on the third edge. RESET lasts exactly 4 cycles with `sys_rst_o`=1, `reg_en_o`=`clk_en_o`=1 and `cpu_run_o`=0. The RAM registers reload their defaults (power all 1, retention all 0). After RESET the mode is ON_IDLE_LP.
- R4: In low-power ON, `mode_o` is 3 (ON_IDLE_LP) with `reg_en_o`=`clk_en_o`=0 while `blk_req_i` is all zero. It is 4 (ON_ACTIVE_LP) with both enables 1 while any request bit is set. This follows `blk_req_i` in the same cycle.
- R5: A `task_clat_i` pulse in ON selects constant latency (code 5, `reg_en_o`=`clk_en_o`=1 with no requests). A `task_lowpwr_i` pulse returns to low power. When both pulse together, constant latency wins.
- R6: `off_wr_i` in ON with `dbg_attached_i`=0 enters OFF (code 1) on the next edge. In OFF, `reg_en_o`, `clk_en_o`, `cpu_run_o`, `dom_en_o` and `ram_pwr_o` are 0 and `ram_ret_o` keeps the retention register. Task and RAM-write inputs are ignored in OFF.
- R7: `off_wr_i` in ON with `dbg_attached_i`=1 enters OFF_EMU (code 2). OFF_EMU has `reg_en_o`=`clk_en_o`=`cpu_run_o`=1 and `dom_en_o`=7'h3F, so every domain except peripherals (bit 6) stays on. `ram_pwr_o` follows the power register.
- R8: In OFF or OFF_EMU, a pulse on `wake_detect_i`, `wake_reset_i` or `wake_dbg_i` starts RESET on the next edge. RESET lasts 4 cycles and is followed by ON_IDLE_LP in the low-power submode. Simultaneous wake events, and wake events that arrive during RESET, give one single reset.
- R9: `ram_wr_i` loads `ram_pwr_d_i`/`ram_ret_d_i` on the next edge, but only in ON. The loaded values survive OFF and wake resets.
- R10: `dom_en_o` bits are clock control 0, power control 1, NVM controller 2, CPU 3, flash 4, RAM 5 and peripherals 6. It is 7'h7F in ON and in RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_en_i | input | 1 | External enable, asynchronous |
| dbg_attached_i | input | 1 | Debugger attached level |
| off_wr_i | input | 1 | Register write requesting deep OFF |
| wake_detect_i | input | 1 | Pin-detect wake pulse |
| wake_reset_i | input | 1 | Reset-request wake pulse |
| wake_dbg_i | input | 1 | Debug-session-start wake pulse |
| task_clat_i | input | 1 | Task pulse: constant-latency submode |
| task_lowpwr_i | input | 1 | Task pulse: low-power submode |
| blk_req_i | input | N_BLK | Function-block activity requests |
| ram_wr_i | input | 1 | RAM control register write strobe |
| ram_pwr_d_i | input | N_RAM | RAM power bits to write |
| ram_ret_d_i | input | N_RAM | RAM retention bits to write |
| reg_en_o | output | 1 | Regulator enable |
| clk_en_o | output | 1 | Clock source enable |
| cpu_run_o | output | 1 | CPU powered and running |
| dom_en_o | output | 7 | Power-domain enables (R10) |
| ram_pwr_o | output | N_RAM | Per-block RAM power |
| ram_ret_o | output | N_RAM | Per-block RAM retention |
| sys_rst_o | output | 1 | System reset pulse |
| mode_o | output | 3 | Mode code |

## Verification
Each result has a fixed latency:

- **External enable:** a change reaches the outputs on the third rising edge, because of the two synchroniser flops plus the state register.
- **Single-edge inputs:** OFF writes, task pulses, wake pulses and RAM writes act on the first edge.
- **Reset sequence:** RESET then covers the following four cycles.
- **Request lines:** these reach `mode_o` and the enables in the same cycle.

The driver pushes each expected output word into a queue, tagged with the exact cycle in which it falls due. The monitor samples a quarter period after each rising edge and compares only the entries due in that cycle. A late or early change is therefore reported as a mismatch.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MODE_DIS     = 3'd0,
    MODE_OFF     = 3'd1,
    MODE_OFF_EMU = 3'd2,
    MODE_ON_IDLE = 3'd3,
    MODE_ON_ACT  = 3'd4,
    MODE_ON_CLAT = 3'd5,
    MODE_RESET   = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    ST_DIS,
    ST_RST,
    ST_ON,
    ST_OFF,
    ST_OFF_EMU
  } st_e;

  localparam int unsigned DOM_W      = 7;
  localparam int unsigned DOM_CLK    = 0;
  localparam int unsigned DOM_PWR    = 1;
  localparam int unsigned DOM_NVM    = 2;
  localparam int unsigned DOM_CPU    = 3;
  localparam int unsigned DOM_FLASH  = 4;
  localparam int unsigned DOM_RAM    = 5;
  localparam int unsigned DOM_PERIPH = 6;

  // domains kept alive while OFF is emulated for a debugger
  localparam logic [DOM_W-1:0] DOM_EMU_KEEP =
    (DOM_W'(1) << DOM_CLK) | (DOM_W'(1) << DOM_PWR) | (DOM_W'(1) << DOM_NVM) |
    (DOM_W'(1) << DOM_CPU) | (DOM_W'(1) << DOM_FLASH) | (DOM_W'(1) << DOM_RAM);

endpackage

// File: rtl/pwr_en_sync.sv
module pwr_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_async_i,
  output logic en_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              en_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      en_d_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], en_async_i};
      en_d_q <= sync_q[STAGES-1];
    end
  end

  assign en_o   = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~en_d_q;

endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(RST_CYC) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = run_i && (cnt_q == CW'(RST_CYC - 1));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic en_rise_i,
  input  logic rst_done_i,
  input  logic off_wr_i,
  input  logic dbg_i,
  input  logic wake_i,
  input  logic clat_i,
  input  logic lowpwr_i,
  output st_e  st_o,
  output logic clat_o,
  output logic go_rst_o
);

  st_e  st_q, st_n;
  logic clat_q, clat_n;

  always_comb begin
    st_n     = st_q;
    clat_n   = clat_q;
    go_rst_o = 1'b0;
    if (!en_i) begin
      st_n   = ST_DIS;
      clat_n = 1'b0;
    end else if (en_rise_i) begin
      st_n     = ST_RST;
      go_rst_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_RST: if (rst_done_i) begin
          st_n   = ST_ON;
          clat_n = 1'b0;
        end
        ST_ON: begin
          if (off_wr_i)      st_n = dbg_i ? ST_OFF_EMU : ST_OFF;
          if (clat_i)        clat_n = 1'b1;
          else if (lowpwr_i) clat_n = 1'b0;
        end
        ST_OFF, ST_OFF_EMU: if (wake_i) begin
          st_n     = ST_RST;
          go_rst_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_DIS;
      clat_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      clat_q <= clat_n;
    end
  end

  assign st_o   = st_q;
  assign clat_o = clat_q;

endmodule

// File: rtl/pwr_ram_ctl.sv
module pwr_ram_ctl #(
  parameter int unsigned       N_RAM   = 4,
  parameter logic [N_RAM-1:0] PWR_DEF = '1,
  parameter logic [N_RAM-1:0] RET_DEF = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             wr_i,
  input  logic [N_RAM-1:0] pwr_d_i,
  input  logic [N_RAM-1:0] ret_d_i,
  output logic [N_RAM-1:0] pwr_o,
  output logic [N_RAM-1:0] ret_o
);

  for (genvar b = 0; b < N_RAM; b++) begin : g_blk
    logic pwr_b, ret_b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pwr_b <= PWR_DEF[b];
        ret_b <= RET_DEF[b];
      end else if (por_i) begin
        pwr_b <= PWR_DEF[b];
        ret_b <= RET_DEF[b];
      end else if (wr_i) begin
        pwr_b <= pwr_d_i[b];
        ret_b <= ret_d_i[b];
      end
    end
    assign pwr_o[b] = pwr_b;
    assign ret_o[b] = ret_b;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned       N_BLK       = 4,
  parameter int unsigned       N_RAM       = 4,
  parameter int unsigned       RST_CYC     = 4,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [N_RAM-1:0] RAM_PWR_DEF = '1,
  parameter logic [N_RAM-1:0] RAM_RET_DEF = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_en_i,
  input  logic             dbg_attached_i,
  input  logic             off_wr_i,
  input  logic             wake_detect_i,
  input  logic             wake_reset_i,
  input  logic             wake_dbg_i,
  input  logic             task_clat_i,
  input  logic             task_lowpwr_i,
  input  logic [N_BLK-1:0] blk_req_i,
  input  logic             ram_wr_i,
  input  logic [N_RAM-1:0] ram_pwr_d_i,
  input  logic [N_RAM-1:0] ram_ret_d_i,
  output logic             reg_en_o,
  output logic             clk_en_o,
  output logic             cpu_run_o,
  output logic [DOM_W-1:0] dom_en_o,
  output logic [N_RAM-1:0] ram_pwr_o,
  output logic [N_RAM-1:0] ram_ret_o,
  output logic             sys_rst_o,
  output logic [2:0]       mode_o
);

  logic             en_s, en_rise, rst_done, go_rst, clat;
  st_e              st;
  logic [N_RAM-1:0] pwr_q, ret_q;
  logic             busy, wake_any;
  mode_e            mode;

  assign busy     = |blk_req_i;
  assign wake_any = wake_detect_i | wake_reset_i | wake_dbg_i;

  pwr_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .en_async_i(ext_en_i), .en_o(en_s), .rise_o(en_rise)
  );

  pwr_rst_timer #(.RST_CYC(RST_CYC)) u_timer (
    .clk_i, .rst_ni, .clr_i(go_rst), .run_i(st == ST_RST), .done_o(rst_done)
  );

  pwr_mode_fsm u_fsm (
    .clk_i, .rst_ni,
    .en_i(en_s), .en_rise_i(en_rise), .rst_done_i(rst_done),
    .off_wr_i, .dbg_i(dbg_attached_i), .wake_i(wake_any),
    .clat_i(task_clat_i), .lowpwr_i(task_lowpwr_i),
    .st_o(st), .clat_o(clat), .go_rst_o(go_rst)
  );

  pwr_ram_ctl #(.N_RAM(N_RAM), .PWR_DEF(RAM_PWR_DEF), .RET_DEF(RAM_RET_DEF)) u_ram (
    .clk_i, .rst_ni,
    .por_i(en_rise), .wr_i(ram_wr_i && st == ST_ON && en_s),
    .pwr_d_i(ram_pwr_d_i), .ret_d_i(ram_ret_d_i),
    .pwr_o(pwr_q), .ret_o(ret_q)
  );

  always_comb begin
    mode      = MODE_DIS;
    reg_en_o  = 1'b0;
    cpu_run_o = 1'b0;
    sys_rst_o = 1'b0;
    dom_en_o  = '0;
    ram_pwr_o = '0;
    ram_ret_o = '0;
    unique case (st)
      ST_RST: begin
        mode      = MODE_RESET;
        sys_rst_o = 1'b1;
        reg_en_o  = 1'b1;
        dom_en_o  = '1;
        ram_pwr_o = pwr_q;
        ram_ret_o = ret_q;
      end
      ST_ON: begin
        mode      = clat ? MODE_ON_CLAT : (busy ? MODE_ON_ACT : MODE_ON_IDLE);
        reg_en_o  = clat | busy;
        cpu_run_o = 1'b1;
        dom_en_o  = '1;
        ram_pwr_o = pwr_q;
        ram_ret_o = ret_q;
      end
      ST_OFF: begin
        mode      = MODE_OFF;
        ram_ret_o = ret_q;
      end
      ST_OFF_EMU: begin
        mode      = MODE_OFF_EMU;
        reg_en_o  = 1'b1;
        cpu_run_o = 1'b1;
        dom_en_o  = DOM_EMU_KEEP;
        ram_pwr_o = pwr_q;
        ram_ret_o = ret_q;
      end
      default: ;
    endcase
  end

  assign clk_en_o = reg_en_o;
  assign mode_o   = mode;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_RAM   = 4,
  parameter int unsigned RST_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wake_detect_i,
  input logic             wake_reset_i,
  input logic             wake_dbg_i,
  input logic             reg_en_o,
  input logic             clk_en_o,
  input logic             cpu_run_o,
  input logic [DOM_W-1:0] dom_en_o,
  input logic [N_RAM-1:0] ram_pwr_o,
  input logic [N_RAM-1:0] ram_ret_o,
  input logic             sys_rst_o,
  input logic [2:0]       mode_o
);

  logic [7:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt_q <= '0;
    else if (sys_rst_o) hi_cnt_q <= hi_cnt_q + 8'd1;
    else                hi_cnt_q <= '0;
  end

  // R1
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_DIS |-> !reg_en_o && !clk_en_o && !cpu_run_o && dom_en_o == '0 && ram_pwr_o == '0);

  // R3
  rst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) && mode_o != MODE_DIS |-> hi_cnt_q == 8'(RST_CYC));

  // R3
  rst_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> hi_cnt_q < 8'(RST_CYC));

  // R4
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_ON_IDLE |-> !reg_en_o && !clk_en_o && cpu_run_o);

  // R6
  off_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_OFF |-> !cpu_run_o && !reg_en_o && dom_en_o == '0 && ram_pwr_o == '0);

  // R7
  emu_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_OFF_EMU |-> cpu_run_o && dom_en_o == DOM_EMU_KEEP);

  // R8
  wake_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_OFF || mode_o == MODE_OFF_EMU) && (wake_detect_i || wake_reset_i || wake_dbg_i)
    |=> sys_rst_o || mode_o == MODE_DIS);

  // R9
  ret_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_OFF && $past(mode_o) == MODE_OFF |-> $stable(ram_ret_o));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_RAM(N_RAM), .RST_CYC(RST_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wake_detect_i(wake_detect_i), .wake_reset_i(wake_reset_i), .wake_dbg_i(wake_dbg_i),
  .reg_en_o(reg_en_o), .clk_en_o(clk_en_o), .cpu_run_o(cpu_run_o), .dom_en_o(dom_en_o),
  .ram_pwr_o(ram_pwr_o), .ram_ret_o(ram_ret_o), .sys_rst_o(sys_rst_o), .mode_o(mode_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int NB    = 4;
  localparam int NR    = 4;
  localparam int OBS_W = 3 + 4 + 7 + 2*NR;

  localparam logic [2:0] M_DIS = 3'd0, M_OFF = 3'd1, M_EMU = 3'd2, M_IDLE = 3'd3,
                         M_ACT = 3'd4, M_CLAT = 3'd5, M_RST = 3'd6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_en_i = 0, dbg_attached_i = 0, off_wr_i = 0;
  logic wake_detect_i = 0, wake_reset_i = 0, wake_dbg_i = 0;
  logic task_clat_i = 0, task_lowpwr_i = 0, ram_wr_i = 0;
  logic [NB-1:0] blk_req_i = '0;
  logic [NR-1:0] ram_pwr_d_i = '0, ram_ret_d_i = '0;
  logic reg_en_o, clk_en_o, cpu_run_o, sys_rst_o;
  logic [6:0] dom_en_o;
  logic [NR-1:0] ram_pwr_o, ram_ret_o;
  logic [2:0] mode_o;

  pwr_mode_ctrl #(.N_BLK(NB), .N_RAM(NR)) dut_i (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int q_due[$];
  string q_req[$];
  logic [OBS_W-1:0] q_val[$];
  logic [NR-1:0] mp = '1, mr = '0;

  wire [OBS_W-1:0] obs = {mode_o, sys_rst_o, reg_en_o, clk_en_o, cpu_run_o, dom_en_o, ram_pwr_o, ram_ret_o};

  function automatic logic [OBS_W-1:0] exp_obs(logic [2:0] m, logic [NR-1:0] p, logic [NR-1:0] r);
    logic rs, re, cp;
    logic [6:0] d;
    logic [NR-1:0] po, ro;
    rs = 0; re = 0; cp = 0; d = '0; po = '0; ro = '0;
    case (m)
      M_RST:  begin rs = 1; re = 1; d = 7'h7F; po = p; ro = r; end
      M_IDLE: begin cp = 1; d = 7'h7F; po = p; ro = r; end
      M_ACT, M_CLAT: begin re = 1; cp = 1; d = 7'h7F; po = p; ro = r; end
      M_OFF:  ro = r;
      M_EMU:  begin re = 1; cp = 1; d = 7'h3F; po = p; ro = r; end
      default: ;
    endcase
    return {m, rs, re, re, cp, d, po, ro};
  endfunction

  task automatic expect_at(int d, string req, logic [2:0] m);
    q_due.push_back(cyc + d);
    q_req.push_back(req);
    q_val.push_back(exp_obs(m, mp, mr));
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor
  initial forever begin
    @(posedge clk_i);
    #(CLK_P/4);
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      n_cmp++;
      if (q_due[0] != cyc || obs !== q_val[0]) begin
        n_bad++;
        $display("FAIL %s cycle %0d got %h expected %h", q_req[0], cyc, obs, q_val[0]);
      end
      void'(q_due.pop_front());
      void'(q_req.pop_front());
      void'(q_val.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    expect_at(1, "R1 reset state", M_DIS);
    tick(2);

    // R2: inputs ignored while disabled
    wake_detect_i = 1; task_clat_i = 1; off_wr_i = 1; ram_wr_i = 1; ram_pwr_d_i = '0;
    expect_at(1, "R2 ignored in disabled", M_DIS);
    tick(1);
    wake_detect_i = 0; task_clat_i = 0; off_wr_i = 0; ram_wr_i = 0;
    expect_at(1, "R2 disabled hold", M_DIS);
    tick(1);

    // R3: power-up sequence
    ext_en_i = 1;
    expect_at(2, "R2 sync latency", M_DIS);
    for (int k = 3; k <= 6; k++) expect_at(k, "R3 reset pulse", M_RST);
    expect_at(7, "R3 R10 on after reset", M_IDLE);
    tick(8);

    // R4: demand tracking
    blk_req_i = 4'b0100;
    expect_at(1, "R4 active", M_ACT);
    tick(1);
    blk_req_i = '0;
    expect_at(1, "R4 idle", M_IDLE);
    tick(1);

    // R5: submode tasks
    task_clat_i = 1;
    expect_at(1, "R5 constlat", M_CLAT);
    tick(1);
    task_clat_i = 0;
    expect_at(1, "R5 constlat holds", M_CLAT);
    tick(1);
    task_clat_i = 1; task_lowpwr_i = 1;
    expect_at(1, "R5 constlat priority", M_CLAT);
    tick(1);
    task_clat_i = 0;
    expect_at(1, "R5 lowpwr", M_IDLE);
    tick(1);
    task_lowpwr_i = 0;

    // R9: RAM control write in ON
    ram_wr_i = 1; ram_pwr_d_i = 4'b0101; ram_ret_d_i = 4'b0011;
    mp = 4'b0101; mr = 4'b0011;
    expect_at(1, "R9 ram write", M_IDLE);
    tick(1);
    ram_wr_i = 0;

    // R6: real OFF from constlat
    task_clat_i = 1;
    expect_at(1, "R5 constlat again", M_CLAT);
    tick(1);
    task_clat_i = 0; off_wr_i = 1;
    expect_at(1, "R6 enter off", M_OFF);
    tick(1);
    off_wr_i = 0;
    task_clat_i = 1; ram_wr_i = 1; ram_pwr_d_i = 4'b1111; ram_ret_d_i = 4'b0000;
    expect_at(1, "R6 R9 inputs ignored in off", M_OFF);
    tick(1);
    task_clat_i = 0; ram_wr_i = 0;
    expect_at(1, "R6 off hold", M_OFF);
    tick(1);

    // R8: simultaneous wake, extra wake during reset
    wake_detect_i = 1; wake_reset_i = 1;
    for (int k = 1; k <= 4; k++) expect_at(k, "R8 single wake reset", M_RST);
    expect_at(5, "R8 R9 on low-power after wake", M_IDLE);
    tick(1);
    wake_detect_i = 0; wake_reset_i = 0; wake_dbg_i = 1;
    tick(1);
    wake_dbg_i = 0;
    tick(4);

    // R7: emulated OFF with debugger attached
    dbg_attached_i = 1; off_wr_i = 1;
    expect_at(1, "R7 emulated off", M_EMU);
    tick(1);
    off_wr_i = 0;
    expect_at(1, "R7 emulated hold", M_EMU);
    tick(1);
    wake_dbg_i = 1;
    for (int k = 1; k <= 4; k++) expect_at(k, "R8 debug wake reset", M_RST);
    expect_at(5, "R8 on after debug wake", M_IDLE);
    tick(1);
    wake_dbg_i = 0;
    tick(5);
    dbg_attached_i = 0;

    // R2: enable low overrides OFF
    off_wr_i = 1;
    expect_at(1, "R6 off again", M_OFF);
    tick(1);
    off_wr_i = 0; ext_en_i = 0;
    expect_at(1, "R2 off before sync", M_OFF);
    expect_at(2, "R2 off before sync", M_OFF);
    expect_at(3, "R2 override to disabled", M_DIS);
    tick(4);

    // R3: re-enable reloads RAM defaults
    ext_en_i = 1;
    mp = '1; mr = '0;
    expect_at(2, "R2 still disabled", M_DIS);
    for (int k = 3; k <= 6; k++) expect_at(k, "R3 reset pulse defaults", M_RST);
    expect_at(7, "R3 ram defaults reloaded", M_IDLE);
    tick(8);

    // R2: enable low overrides active ON
    blk_req_i = 4'b1001; ext_en_i = 0;
    expect_at(1, "R4 active again", M_ACT);
    expect_at(2, "R2 active before sync", M_ACT);
    expect_at(3, "R2 disabled from active", M_DIS);
    tick(4);
    blk_req_i = '0;
    tick(2);

    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL queue not drained: %0d left, expected 0", q_due.size());
    end
    summary();
  end

endmodule